// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block turns one page-program, erase or status request into the complete command sequence a serial NOR flash expects. For program and erase it first reads the device status to make sure no earlier write is still running, then sends write-enable, then the program or erase command with its address and any data bytes. After that it keeps reading the status register, with a fixed gap between reads, until the write-in-progress flag clears. Only then does it report completion. A status request performs a single status read and returns the byte.

Requests are checked before anything reaches the bus. A program must stay inside one page and carry at most the smaller of 64 bytes and the page size. An erase is accepted only when its byte count exactly equals one of the configured, non-zero erase sizes or the chip-erase code. Every request is refused while execute-in-place mode is active. Each serial frame is handed to a frame engine below this block, which does the bit shifting.

The request port and both data streams are valid/ready. A request must be held with its fields stable until `req_ready` is seen high; `req_ready` is high only when the sequencer is idle. Program data bytes move from `wdat_*` to `fd_*` combinationally, and only after the program frame has been accepted and before that frame completes; outside that window `wdat_ready` and `fd_valid` are low, so the data source is simply stalled. A frame on `frm_*` is held, fields stable, until `frm_ready`.

Top module: `flash_pe_sequencer`

## Requirements
- R1: Every program or erase command frame is preceded, as the frame immediately before it, by a write-enable frame with opcode 0x06, no address and no data.
- R2: A program request (req_op 0) sends opcode 0x02 with the request address and frm_len equal to the byte count, and the data bytes pass from wdat to fd in order and unchanged.
- R3: A program request whose count is 0, above min(64, page size), or whose bytes would run past the end of the page containing the start address, ends with err and err_code 1 and sends no frame; a range ending exactly on the page end is accepted.
- R4: An erase request (req_op 1) picks its opcode by exact count: 4096 gives 0x20, 32768 gives 0x52, 65536 gives 0xD8, each with an address; the chip-erase code 0xFFFFFFFF gives 0xC7 with zero address bytes.
- R5: An erase count that matches no size, or that matches only a size configured as 0, ends with err and err_code 1 and sends no frame.
- R6: Status reads use opcode 0x05 with one data byte read back, and the busy flag is taken from bit WIP_BIT of that byte.
- R7: Before write-enable, a program or erase request reads status once; if the busy flag is set the request ends with err and err_code 2 and no further frame.
- R8: After the command frame, status is read repeatedly with at least GAP_CYCLES cycles between frames; done pulses only after a read shows the busy flag clear.
- R9: While xip_active is high at acceptance, program, erase and status requests end with err and err_code 3 two cycles after the request handshake and send no frame.
- R10: With ADDR_BYTES = 3 the frame carries only the low 24 address bits (upper byte zero) and frm_addr_bytes is 3.
- R11: A status request (req_op 2) sends one status frame and pulses done with the read byte on stat_byte; req_op 3 ends with err code 1.
- R12: done and err are never high in the same cycle, and req_ready is low while any frame is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xip_active | input | 1 | Execute-in-place mode is on; requests are refused |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request taken on this edge |
| req_op | input | 2 | 0 program, 1 erase, 2 status, 3 reserved |
| req_addr | input | 32 | Flash byte address |
| req_count | input | 32 | Program byte count or erase size |
| wdat_valid | input | 1 | Program data byte offered |
| wdat_ready | output | 1 | Program data byte taken |
| wdat_byte | input | 8 | Program data byte |
| frm_valid | output | 1 | Frame request to the frame engine |
| frm_ready | input | 1 | Frame engine accepts the frame |
| frm_cmd | output | 8 | Opcode |
| frm_addr | output | 32 | Address to send |
| frm_addr_bytes | output | 3 | Number of address bytes, 0 for none |
| frm_len | output | LEN_W | Data byte count |
| frm_read | output | 1 | Data phase reads from the device |
| frm_done | input | 1 | One-cycle pulse, frame finished |
| frm_rdata | input | 8 | Byte read by the last frame |
| fd_valid | output | 1 | Data byte towards the frame engine |
| fd_ready | input | 1 | Frame engine takes the data byte |
| fd_byte | output | 8 | Data byte |
| done | output | 1 | One-cycle pulse, request completed |
| err | output | 1 | One-cycle pulse, request refused |
| err_code | output | 2 | 1 invalid, 2 device busy, 3 execute-in-place |
| stat_byte | output | 8 | Last status byte read |

## Verification
A wrong sequencing state shows up directly on the frame port: a missing write-enable, an opcode out of place or a poll that stops while the busy flag is still set appears as a frame that differs from the expected list within one frame of the fault. A wrong validation decision shows two cycles after the handshake as an err where done was due, or as an unexpected status frame where an err was due. A corrupted poll loop shows either as done arriving before the status read that reports clear, or as reads that come closer together than the configured gap.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;

  typedef enum logic [1:0] {
    OP_PROG   = 2'd0,
    OP_ERASE  = 2'd1,
    OP_STATUS = 2'd2,
    OP_RSVD   = 2'd3
  } fpe_op_e;

  typedef enum logic [1:0] {
    EC_NONE    = 2'd0,
    EC_INVALID = 2'd1,
    EC_BUSY    = 2'd2,
    EC_XIP     = 2'd3
  } fpe_err_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_CHECK,
    S_PRE_ISS,
    S_PRE_WT,
    S_WREN_ISS,
    S_WREN_WT,
    S_CMD_ISS,
    S_CMD_WT,
    S_GAP,
    S_POLL_ISS,
    S_POLL_WT
  } fpe_state_e;

  localparam logic [7:0] OPC_WREN     = 8'h06;
  localparam logic [7:0] OPC_PROG     = 8'h02;
  localparam logic [7:0] OPC_RDSR     = 8'h05;
  localparam logic [7:0] OPC_ERS_SECT = 8'h20;
  localparam logic [7:0] OPC_ERS_B32  = 8'h52;
  localparam logic [7:0] OPC_ERS_B64  = 8'hD8;
  localparam logic [7:0] OPC_ERS_CHIP = 8'hC7;

  localparam int N_ERASE_KINDS = 3;

endpackage

// File: rtl/flash_pe_check.sv
module flash_pe_check
  import flash_pe_pkg::*;
#(
  parameter int          PAGE_BYTES = 256,
  parameter int          MAX_PROG   = 64,
  parameter int          ADDR_BYTES = 3,
  parameter int          SECT_SIZE  = 4096,
  parameter int          BLK32_SIZE = 32768,
  parameter int          BLK64_SIZE = 65536,
  parameter logic [31:0] CHIP_CODE  = 32'hFFFF_FFFF,
  parameter int          LEN_W      = 7
) (
  input  logic [1:0]       op,
  input  logic [31:0]      addr,
  input  logic [31:0]      count,
  input  logic             xip,
  output logic             reject,
  output fpe_err_e         code,
  output logic [7:0]       cmd,
  output logic [31:0]      faddr,
  output logic [2:0]       abytes,
  output logic [LEN_W-1:0] len,
  output logic             is_status,
  output logic             is_prog
);

  localparam int          MAXW      = (MAX_PROG < PAGE_BYTES) ? MAX_PROG : PAGE_BYTES;
  localparam logic [31:0] PAGE_MASK = 32'(PAGE_BYTES - 1);
  localparam logic [2:0]  AB        = 3'(ADDR_BYTES);

  localparam logic [31:0] ERS_SIZE [N_ERASE_KINDS] =
    '{32'(SECT_SIZE), 32'(BLK32_SIZE), 32'(BLK64_SIZE)};
  localparam logic [7:0]  ERS_OPC  [N_ERASE_KINDS] =
    '{OPC_ERS_SECT, OPC_ERS_B32, OPC_ERS_B64};

  logic [32:0] span;
  logic        prog_ok;
  logic [N_ERASE_KINDS-1:0] ers_hit;

  assign span    = {1'b0, addr & PAGE_MASK} + {1'b0, count};
  assign prog_ok = (count != 32'd0) && (count <= 32'(MAXW)) &&
                   (span <= 33'(PAGE_BYTES));

  for (genvar k = 0; k < N_ERASE_KINDS; k++) begin : g_ers
    assign ers_hit[k] = (ERS_SIZE[k] != 32'd0) && (count == ERS_SIZE[k]);
  end

  if (ADDR_BYTES == 3) begin : g_a3
    assign faddr = {8'h00, addr[23:0]};
  end else begin : g_a4
    assign faddr = addr;
  end

  always_comb begin
    reject    = 1'b0;
    code      = EC_NONE;
    cmd       = 8'h00;
    abytes    = 3'd0;
    len       = '0;
    is_status = 1'b0;
    is_prog   = 1'b0;
    if (xip) begin
      reject = 1'b1;
      code   = EC_XIP;
    end else begin
      case (fpe_op_e'(op))
        OP_PROG: begin
          if (prog_ok) begin
            cmd     = OPC_PROG;
            abytes  = AB;
            len     = count[LEN_W-1:0];
            is_prog = 1'b1;
          end else begin
            reject = 1'b1;
            code   = EC_INVALID;
          end
        end
        OP_ERASE: begin
          if (count == CHIP_CODE) begin
            cmd = OPC_ERS_CHIP;
          end else if (ers_hit != '0) begin
            abytes = AB;
            for (int k = N_ERASE_KINDS - 1; k >= 0; k--) begin
              if (ers_hit[k]) cmd = ERS_OPC[k];
            end
          end else begin
            reject = 1'b1;
            code   = EC_INVALID;
          end
        end
        OP_STATUS: is_status = 1'b1;
        default: begin
          reject = 1'b1;
          code   = EC_INVALID;
        end
      endcase
    end
  end

endmodule

// File: rtl/flash_pe_gap_timer.sv
module flash_pe_gap_timer #(
  parameter int GAP_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expired
);

  localparam int CW = (GAP_CYCLES > 0) ? $clog2(GAP_CYCLES + 1) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (start) begin
      cnt <= CW'(GAP_CYCLES);
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0) && !start;

endmodule

// File: rtl/flash_pe_ctrl.sv
module flash_pe_ctrl
  import flash_pe_pkg::*;
#(
  parameter int WIP_BIT = 0,
  parameter int LEN_W   = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_fire,
  input  logic             chk_reject,
  input  fpe_err_e         chk_code,
  input  logic [7:0]       chk_cmd,
  input  logic [31:0]      chk_addr,
  input  logic [2:0]       chk_abytes,
  input  logic [LEN_W-1:0] chk_len,
  input  logic             chk_is_status,
  input  logic             chk_is_prog,
  input  logic             frm_ready,
  input  logic             frm_done,
  input  logic [7:0]       frm_rdata,
  input  logic             gap_expired,
  output logic             frm_valid,
  output logic [7:0]       frm_cmd,
  output logic [31:0]      frm_addr,
  output logic [2:0]       frm_addr_bytes,
  output logic [LEN_W-1:0] frm_len,
  output logic             frm_read,
  output logic             gap_start,
  output logic             data_phase,
  output logic             idle,
  output logic             done,
  output logic             err,
  output logic [1:0]       err_code,
  output logic [7:0]       stat_byte
);

  fpe_state_e       state, state_nx;
  logic [7:0]       p_cmd;
  logic [31:0]      p_addr;
  logic [2:0]       p_abytes;
  logic [LEN_W-1:0] p_len;
  logic             p_status;
  logic             p_prog;
  logic             wip;

  assign wip = frm_rdata[WIP_BIT];

  always_comb begin
    state_nx = state;
    case (state)
      S_IDLE:     if (req_fire) state_nx = S_CHECK;
      S_CHECK:    state_nx = chk_reject ? S_IDLE : S_PRE_ISS;
      S_PRE_ISS:  if (frm_ready) state_nx = S_PRE_WT;
      S_PRE_WT:   if (frm_done) state_nx = (p_status || wip) ? S_IDLE : S_WREN_ISS;
      S_WREN_ISS: if (frm_ready) state_nx = S_WREN_WT;
      S_WREN_WT:  if (frm_done) state_nx = S_CMD_ISS;
      S_CMD_ISS:  if (frm_ready) state_nx = S_CMD_WT;
      S_CMD_WT:   if (frm_done) state_nx = S_GAP;
      S_GAP:      if (gap_expired) state_nx = S_POLL_ISS;
      S_POLL_ISS: if (frm_ready) state_nx = S_POLL_WT;
      S_POLL_WT:  if (frm_done) state_nx = wip ? S_GAP : S_IDLE;
      default:    state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      p_cmd     <= 8'h00;
      p_addr    <= '0;
      p_abytes  <= '0;
      p_len     <= '0;
      p_status  <= 1'b0;
      p_prog    <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      err_code  <= EC_NONE;
      stat_byte <= 8'h00;
    end else begin
      state <= state_nx;
      done  <= 1'b0;
      err   <= 1'b0;
      if (state == S_CHECK) begin
        if (chk_reject) begin
          err      <= 1'b1;
          err_code <= chk_code;
        end else begin
          p_cmd    <= chk_cmd;
          p_addr   <= chk_addr;
          p_abytes <= chk_abytes;
          p_len    <= chk_len;
          p_status <= chk_is_status;
          p_prog   <= chk_is_prog;
        end
      end
      if (frm_done && (state == S_PRE_WT || state == S_POLL_WT)) begin
        stat_byte <= frm_rdata;
      end
      if (state == S_PRE_WT && frm_done) begin
        if (p_status) begin
          done     <= 1'b1;
          err_code <= EC_NONE;
        end else if (wip) begin
          err      <= 1'b1;
          err_code <= EC_BUSY;
        end
      end
      if (state == S_POLL_WT && frm_done && !wip) begin
        done     <= 1'b1;
        err_code <= EC_NONE;
      end
    end
  end

  always_comb begin
    frm_valid      = 1'b0;
    frm_cmd        = 8'h00;
    frm_addr       = '0;
    frm_addr_bytes = 3'd0;
    frm_len        = '0;
    frm_read       = 1'b0;
    case (state)
      S_PRE_ISS, S_POLL_ISS: begin
        frm_valid = 1'b1;
        frm_cmd   = OPC_RDSR;
        frm_len   = LEN_W'(1);
        frm_read  = 1'b1;
      end
      S_WREN_ISS: begin
        frm_valid = 1'b1;
        frm_cmd   = OPC_WREN;
      end
      S_CMD_ISS: begin
        frm_valid      = 1'b1;
        frm_cmd        = p_cmd;
        frm_addr       = p_addr;
        frm_addr_bytes = p_abytes;
        frm_len        = p_len;
      end
      default: ;
    endcase
  end

  assign gap_start  = frm_done && ((state == S_CMD_WT) || (state == S_POLL_WT && wip));
  assign data_phase = (state == S_CMD_WT) && p_prog;
  assign idle       = (state == S_IDLE);

endmodule

// File: rtl/flash_pe_sequencer.sv
module flash_pe_sequencer
  import flash_pe_pkg::*;
#(
  parameter int          PAGE_BYTES = 256,
  parameter int          MAX_PROG   = 64,
  parameter int          ADDR_BYTES = 3,
  parameter int          WIP_BIT    = 0,
  parameter int          GAP_CYCLES = 16,
  parameter int          SECT_SIZE  = 4096,
  parameter int          BLK32_SIZE = 32768,
  parameter int          BLK64_SIZE = 65536,
  parameter logic [31:0] CHIP_CODE  = 32'hFFFF_FFFF,
  parameter int          LEN_W      = $clog2(((MAX_PROG < PAGE_BYTES) ? MAX_PROG : PAGE_BYTES) + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xip_active,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [31:0]      req_addr,
  input  logic [31:0]      req_count,
  input  logic             wdat_valid,
  output logic             wdat_ready,
  input  logic [7:0]       wdat_byte,
  output logic             frm_valid,
  input  logic             frm_ready,
  output logic [7:0]       frm_cmd,
  output logic [31:0]      frm_addr,
  output logic [2:0]       frm_addr_bytes,
  output logic [LEN_W-1:0] frm_len,
  output logic             frm_read,
  input  logic             frm_done,
  input  logic [7:0]       frm_rdata,
  output logic             fd_valid,
  input  logic             fd_ready,
  output logic [7:0]       fd_byte,
  output logic             done,
  output logic             err,
  output logic [1:0]       err_code,
  output logic [7:0]       stat_byte
);

  logic             req_fire;
  logic [1:0]       rq_op;
  logic [31:0]      rq_addr;
  logic [31:0]      rq_count;
  logic             rq_xip;

  logic             chk_reject;
  fpe_err_e         chk_code;
  logic [7:0]       chk_cmd;
  logic [31:0]      chk_addr;
  logic [2:0]       chk_abytes;
  logic [LEN_W-1:0] chk_len;
  logic             chk_is_status;
  logic             chk_is_prog;

  logic             gap_start;
  logic             gap_expired;
  logic             data_phase;
  logic             idle;

  assign req_ready = idle;
  assign req_fire  = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rq_op    <= '0;
      rq_addr  <= '0;
      rq_count <= '0;
      rq_xip   <= 1'b0;
    end else if (req_fire) begin
      rq_op    <= req_op;
      rq_addr  <= req_addr;
      rq_count <= req_count;
      rq_xip   <= xip_active;
    end
  end

  flash_pe_check #(
    .PAGE_BYTES (PAGE_BYTES),
    .MAX_PROG   (MAX_PROG),
    .ADDR_BYTES (ADDR_BYTES),
    .SECT_SIZE  (SECT_SIZE),
    .BLK32_SIZE (BLK32_SIZE),
    .BLK64_SIZE (BLK64_SIZE),
    .CHIP_CODE  (CHIP_CODE),
    .LEN_W      (LEN_W)
  ) u_check (
    .op        (rq_op),
    .addr      (rq_addr),
    .count     (rq_count),
    .xip       (rq_xip),
    .reject    (chk_reject),
    .code      (chk_code),
    .cmd       (chk_cmd),
    .faddr     (chk_addr),
    .abytes    (chk_abytes),
    .len       (chk_len),
    .is_status (chk_is_status),
    .is_prog   (chk_is_prog)
  );

  flash_pe_gap_timer #(
    .GAP_CYCLES (GAP_CYCLES)
  ) u_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (gap_start),
    .expired (gap_expired)
  );

  flash_pe_ctrl #(
    .WIP_BIT (WIP_BIT),
    .LEN_W   (LEN_W)
  ) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_fire       (req_fire),
    .chk_reject     (chk_reject),
    .chk_code       (chk_code),
    .chk_cmd        (chk_cmd),
    .chk_addr       (chk_addr),
    .chk_abytes     (chk_abytes),
    .chk_len        (chk_len),
    .chk_is_status  (chk_is_status),
    .chk_is_prog    (chk_is_prog),
    .frm_ready      (frm_ready),
    .frm_done       (frm_done),
    .frm_rdata      (frm_rdata),
    .gap_expired    (gap_expired),
    .frm_valid      (frm_valid),
    .frm_cmd        (frm_cmd),
    .frm_addr       (frm_addr),
    .frm_addr_bytes (frm_addr_bytes),
    .frm_len        (frm_len),
    .frm_read       (frm_read),
    .gap_start      (gap_start),
    .data_phase     (data_phase),
    .idle           (idle),
    .done           (done),
    .err            (err),
    .err_code       (err_code),
    .stat_byte      (stat_byte)
  );

  assign fd_valid   = wdat_valid && data_phase;
  assign wdat_ready = fd_ready && data_phase;
  assign fd_byte    = wdat_byte;

endmodule

// File: rtl/flash_pe_sequencer_sva.sv
module flash_pe_sequencer_sva #(
  parameter int WIP_BIT = 0,
  parameter int MAXW    = 64,
  parameter int LEN_W   = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             xip_active,
  input logic             req_valid,
  input logic             req_ready,
  input logic             frm_valid,
  input logic             frm_ready,
  input logic [7:0]       frm_cmd,
  input logic [LEN_W-1:0] frm_len,
  input logic             frm_done,
  input logic [7:0]       frm_rdata,
  input logic             fd_valid,
  input logic             done,
  input logic             err,
  input logic [1:0]       err_code
);

  logic [7:0] last_cmd;
  logic       last_wip;
  logic       cmd_seen;
  logic       is_mod;

  assign is_mod = (frm_cmd == 8'h02) || (frm_cmd == 8'h20) || (frm_cmd == 8'h52) ||
                  (frm_cmd == 8'hD8) || (frm_cmd == 8'hC7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_cmd <= 8'h00;
      last_wip <= 1'b0;
      cmd_seen <= 1'b0;
    end else begin
      if (frm_valid && frm_ready) last_cmd <= frm_cmd;
      if (frm_done && last_cmd == 8'h05) last_wip <= frm_rdata[WIP_BIT];
      if (done || err) cmd_seen <= 1'b0;
      else if (frm_valid && frm_ready && is_mod) cmd_seen <= 1'b1;
    end
  end

  a_r1_wren_first: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && frm_ready && is_mod |-> last_cmd == 8'h06);

  a_r2_prog_len: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && frm_cmd == 8'h02 |-> (frm_len != '0) && (int'(frm_len) <= MAXW));

  a_r12_frame_hold: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && !frm_ready |=> frm_valid && $stable(frm_cmd) && $stable(frm_len));

  a_r2_data_window: assert property (@(posedge clk) disable iff (!rst_n)
    fd_valid |-> last_cmd == 8'h02);

  a_r8_done_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
    done && cmd_seen |-> !last_wip);

  a_r9_xip_refused: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && xip_active |=> ##1 (err && err_code == 2'd3));

  a_r12_done_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  a_r12_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && frm_valid));

endmodule

bind flash_pe_sequencer flash_pe_sequencer_sva #(
  .WIP_BIT (WIP_BIT),
  .MAXW    ((MAX_PROG < PAGE_BYTES) ? MAX_PROG : PAGE_BYTES),
  .LEN_W   (LEN_W)
) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .xip_active (xip_active),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .frm_valid  (frm_valid),
  .frm_ready  (frm_ready),
  .frm_cmd    (frm_cmd),
  .frm_len    (frm_len),
  .frm_done   (frm_done),
  .frm_rdata  (frm_rdata),
  .fd_valid   (fd_valid),
  .done       (done),
  .err        (err),
  .err_code   (err_code)
);

// File: tb/flash_pe_sequencer_tb.sv
module flash_pe_sequencer_tb;

  localparam int GAP        = 4;
  localparam int BUSY_READS = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        xip_active = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = '0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_count = '0;
  logic        wdat_valid = 1'b0;
  logic        wdat_ready;
  logic [7:0]  wdat_byte = '0;
  logic        frm_valid;
  logic        frm_ready = 1'b0;
  logic [7:0]  frm_cmd;
  logic [31:0] frm_addr;
  logic [2:0]  frm_addr_bytes;
  logic [6:0]  frm_len;
  logic        frm_read;
  logic        frm_done = 1'b0;
  logic [7:0]  frm_rdata = '0;
  logic        fd_valid;
  logic        fd_ready = 1'b0;
  logic [7:0]  fd_byte;
  logic        done, err;
  logic [1:0]  err_code;
  logic [7:0]  stat_byte;

  flash_pe_sequencer #(.WIP_BIT(3), .GAP_CYCLES(GAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .xip_active(xip_active),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_count(req_count),
    .wdat_valid(wdat_valid), .wdat_ready(wdat_ready), .wdat_byte(wdat_byte),
    .frm_valid(frm_valid), .frm_ready(frm_ready), .frm_cmd(frm_cmd),
    .frm_addr(frm_addr), .frm_addr_bytes(frm_addr_bytes), .frm_len(frm_len),
    .frm_read(frm_read), .frm_done(frm_done), .frm_rdata(frm_rdata),
    .fd_valid(fd_valid), .fd_ready(fd_ready), .fd_byte(fd_byte),
    .done(done), .err(err), .err_code(err_code), .stat_byte(stat_byte));

  // second instance with the 64 KiB erase size disabled
  logic        n_req_valid = 1'b0;
  logic        n_req_ready, n_wdat_ready, n_frm_valid, n_frm_read, n_fd_valid;
  logic [7:0]  n_frm_cmd, n_fd_byte, n_stat;
  logic [31:0] n_frm_addr;
  logic [2:0]  n_frm_ab;
  logic [6:0]  n_frm_len;
  logic        n_done, n_err;
  logic [1:0]  n_err_code;

  flash_pe_sequencer #(.BLK64_SIZE(0)) u_dut_nob64 (
    .clk(clk), .rst_n(rst_n), .xip_active(1'b0),
    .req_valid(n_req_valid), .req_ready(n_req_ready), .req_op(2'd1),
    .req_addr(32'h0001_0000), .req_count(32'd65536),
    .wdat_valid(1'b0), .wdat_ready(n_wdat_ready), .wdat_byte(8'h00),
    .frm_valid(n_frm_valid), .frm_ready(1'b0), .frm_cmd(n_frm_cmd),
    .frm_addr(n_frm_addr), .frm_addr_bytes(n_frm_ab), .frm_len(n_frm_len),
    .frm_read(n_frm_read), .frm_done(1'b0), .frm_rdata(8'h00),
    .fd_valid(n_fd_valid), .fd_ready(1'b0), .fd_byte(n_fd_byte),
    .done(n_done), .err(n_err), .err_code(n_err_code), .stat_byte(n_stat));

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [7:0]  cmd;
    logic [31:0] addr;
    int          ab;
    int          len;
    string       tag;
  } frm_t;

  frm_t       expq[$];
  logic [7:0] wq[$];
  int         wip_count = 0;
  int         last05 = -1;
  int         min_gap = 1000000;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic exp_frame(input logic [7:0] c, input logic [31:0] a,
                           input int ab, input int len, input string tag);
    frm_t f;
    f.cmd = c; f.addr = a; f.ab = ab; f.len = len; f.tag = tag;
    expq.push_back(f);
  endtask

  // full program/erase sequence: precheck, write-enable, command, polls
  task automatic exp_sequence(input logic [7:0] c, input logic [31:0] a,
                              input int ab, input int len, input string tag);
    exp_frame(8'h05, 0, 0, 1, "R7");
    exp_frame(8'h06, 0, 0, 0, "R1");
    exp_frame(c, a, ab, len, tag);
    for (int i = 0; i <= BUSY_READS; i++) exp_frame(8'h05, 0, 0, 1, "R8");
  endtask

  // frame engine model and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      frm_ready = 1'b0;
      frm_done  = 1'b0;
      if (frm_valid) begin
        frm_t       f;
        logic [7:0] c;
        logic [7:0] rd;
        int         n;
        bit         data_ok;
        @(negedge clk);
        frm_ready = 1'b1;
        #1;
        c  = frm_cmd;
        rd = 8'h00;
        if (expq.size() == 0) begin
          check(0, "R1", "unexpected frame opcode", c, 0);
        end else begin
          f = expq.pop_front();
          check(c == f.cmd && frm_addr == f.addr && int'(frm_addr_bytes) == f.ab &&
                int'(frm_len) == f.len && frm_read == (c == 8'h05),
                f.tag, "frame opcode/addr", {c, frm_addr}, {f.cmd, f.addr});
        end
        if (c == 8'h05) begin
          if (last05 >= 0 && (cyc - last05) < min_gap) min_gap = cyc - last05;
          last05 = cyc;
          rd = (wip_count > 0) ? 8'h48 : 8'h41;
          if (wip_count > 0) wip_count--;
        end
        n = int'(frm_len);
        @(negedge clk);
        frm_ready = 1'b0;
        if (c == 8'h02) begin
          data_ok = 1'b1;
          while (n > 0) begin
            @(negedge clk);
            fd_ready   = 1'b1;
            wdat_valid = (wq.size() > 0);
            wdat_byte  = (wq.size() > 0) ? wq[0] : 8'h00;
            #1;
            if (fd_valid && fd_ready) begin
              if (fd_byte != wq[0]) data_ok = 1'b0;
              void'(wq.pop_front());
              n--;
            end
          end
          @(negedge clk);
          fd_ready   = 1'b0;
          wdat_valid = 1'b0;
          check(data_ok, "R2", "program data bytes passed in order", data_ok, 1);
        end
        if (c == 8'h02 || c == 8'h20 || c == 8'h52 || c == 8'hD8 || c == 8'hC7)
          wip_count = BUSY_READS;
        frm_done  = 1'b1;
        frm_rdata = rd;
      end
    end
  end

  // driver: issue one request and check its outcome
  task automatic run_req(input logic [1:0] op, input logic [31:0] a, input logic [31:0] cnt,
                         input bit exp_err, input logic [1:0] exp_code,
                         input bit chk_stat, input logic [7:0] exp_stat, input string tag);
    bit got_done, got_err;
    logic [1:0] code;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_count = cnt;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    req_valid = 1'b0;
    got_done = 1'b0; got_err = 1'b0; code = 2'd0;
    for (int k = 0; k < 3000; k++) begin
      if (done || err) begin
        got_done = done; got_err = err; code = err_code;
        break;
      end
      @(negedge clk);
    end
    check(got_err == exp_err && got_done == !exp_err, tag, "outcome err/done",
          {got_err, got_done}, {exp_err, !exp_err});
    if (exp_err) check(code == exp_code, tag, "err_code", code, exp_code);
    if (chk_stat) check(stat_byte == exp_stat, tag, "stat_byte", stat_byte, exp_stat);
    check(expq.size() == 0, tag, "frames still expected", expq.size(), 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "WATCHDOG", "run did not finish", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !done && !err && !frm_valid, "R12", "reset state",
          {req_ready, done, err, frm_valid}, 4'b1000);

    // R2 R10 R8 R6: program with high address bits set
    for (int i = 0; i < 16; i++) wq.push_back(8'(8'hA0 + i));
    exp_sequence(8'h02, 32'h0034_5610, 3, 16, "R10");
    min_gap = 1000000;
    run_req(2'd0, 32'hAB34_5610, 32'd16, 0, 0, 1, 8'h41, "R2");
    check(min_gap >= GAP, "R8", "status poll spacing", min_gap, GAP);

    // R3: range ending exactly on the page end is accepted
    for (int i = 0; i < 64; i++) wq.push_back(8'(i * 7 + 3));
    exp_sequence(8'h02, 32'h0000_01C0, 3, 64, "R3");
    run_req(2'd0, 32'h0000_01C0, 32'd64, 0, 0, 0, 0, "R3");

    // R3: page crossing, zero count, too many bytes
    run_req(2'd0, 32'h0000_01C1, 32'd64, 1, 2'd1, 0, 0, "R3");
    run_req(2'd0, 32'h0000_0000, 32'd0, 1, 2'd1, 0, 0, "R3");
    run_req(2'd0, 32'h0000_0000, 32'd65, 1, 2'd1, 0, 0, "R3");

    // R4: erase opcode by exact size
    exp_sequence(8'h20, 32'h0001_2000, 3, 0, "R4");
    run_req(2'd1, 32'h0001_2000, 32'd4096, 0, 0, 0, 0, "R4");
    exp_sequence(8'h52, 32'h0010_8000, 3, 0, "R4");
    run_req(2'd1, 32'hFF10_8000, 32'd32768, 0, 0, 0, 0, "R4");
    exp_sequence(8'hD8, 32'h0002_0000, 3, 0, "R4");
    run_req(2'd1, 32'h0002_0000, 32'd65536, 0, 0, 0, 0, "R4");
    exp_sequence(8'hC7, 32'h0000_0000, 0, 0, "R4");
    run_req(2'd1, 32'h0000_0000, 32'hFFFF_FFFF, 0, 0, 0, 0, "R4");

    // R5: unmatched size, and a size configured as zero
    run_req(2'd1, 32'h0000_0000, 32'd8192, 1, 2'd1, 0, 0, "R5");
    begin
      bit got;
      logic [1:0] code;
      @(negedge clk);
      n_req_valid = 1'b1;
      #1;
      while (!n_req_ready) begin
        @(negedge clk);
        #1;
      end
      @(negedge clk);
      n_req_valid = 1'b0;
      got = 1'b0; code = 2'd0;
      for (int k = 0; k < 20; k++) begin
        if (n_err || n_done) begin
          got = n_err; code = n_err_code;
          break;
        end
        @(negedge clk);
      end
      check(got && code == 2'd1, "R5", "disabled 64K erase size refused", {got, code}, 3'b101);
    end

    // R7: device busy at precheck
    wip_count = 1;
    exp_frame(8'h05, 0, 0, 1, "R7");
    run_req(2'd1, 32'h0000_1000, 32'd4096, 1, 2'd2, 1, 8'h48, "R7");

    // R11 R6: status requests (busy byte then clear byte)
    wip_count = 1;
    exp_frame(8'h05, 0, 0, 1, "R11");
    run_req(2'd2, 32'h0, 32'd0, 0, 0, 1, 8'h48, "R11");
    exp_frame(8'h05, 0, 0, 1, "R6");
    run_req(2'd2, 32'h0, 32'd0, 0, 0, 1, 8'h41, "R6");
    run_req(2'd3, 32'h0, 32'd0, 1, 2'd1, 0, 0, "R11");

    // R9: execute-in-place refuses everything
    xip_active = 1'b1;
    run_req(2'd0, 32'h0, 32'd4, 1, 2'd3, 0, 0, "R9");
    run_req(2'd1, 32'h0, 32'd4096, 1, 2'd3, 0, 0, "R9");
    run_req(2'd2, 32'h0, 32'd0, 1, 2'd3, 0, 0, "R9");
    xip_active = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule